// File: doc/BRIEF.md
# Four-Register Bus Datapath

This block is a single-cycle register-transfer datapath. Four W-bit registers feed two read buses. Bus A carries any one register. Bus B carries any one register, or an external constant when the constant path is selected. Both buses drive a combinational function unit. That unit holds an arithmetic/logic unit working on A and B, and a one-bit shifter working on B. A select bit picks which of the two results goes out.

The chosen result is written back into one destination register on the next rising clock edge. The write happens only when the write enable is high. So one micro-operation (read the sources, operate, write the destination) takes one clock. Status flags for carry, overflow, negative and zero follow the current result combinationally. A control unit outside this block sequences the micro-operations.

There is no state machine. The only stored state is the register file. A synchronous active-high reset clears it. Operation codes are enumerations: `OP_PASS`, `OP_INC`, `OP_ADD`, `OP_SUB`, `OP_AND`, `OP_OR`, `OP_XOR` and `OP_NOT` for the ALU, and `SH_PASS`, `SH_LEFT`, `SH_RIGHT` and `SH_HOLD` for the shifter.

Top module: `regfile_datapath`

## Requirements
- R1: When `rst` is high at a rising edge, all four registers become zero. Afterwards every register reads as zero on both buses.
- R2: `bus_a` shows the register addressed by `a_sel`. `bus_b` shows the register addressed by `b_sel` when `b_use_const` is 0, and shows `const_in` when `b_use_const` is 1.
- R3: A register loads only at a rising edge where `wr_en` is 1 and `dst_sel` equals its index (0 to 3). All other registers keep their values. When `wr_en` is 0, no register changes.
- R4: If a cycle reads the same register that it writes, the bus carries the old value in that cycle. The new value appears from the next cycle on.
- R5: The arithmetic codes of `alu_op` are as follows. Code 0 gives A. Code 1 gives A+1. Code 2 gives A+B. Code 3 gives A−B, formed as A + ~B + 1. `flag_c` is the adder's carry out; for subtraction, 1 means no borrow. `flag_v` is signed two's-complement overflow. Code 0 gives C=V=0.
- R6: The logic codes of `alu_op` are 4 (A AND B), 5 (A OR B), 6 (A XOR B) and 7 (NOT A). All four give C=V=0.
- R7: The shifter works on bus B. `shift_op` 0 and 3 pass B unchanged. Code 1 shifts left one bit: the MSB is dropped and a 0 enters the LSB. Code 2 shifts right one bit: the LSB is dropped and a 0 enters the MSB. When `use_shifter` is 1, `result` is the shifter output and C=V=0. When it is 0, `result` is the ALU output.
- R8: `flag_n` equals the MSB of `result`. `flag_z` is 1 exactly when every bit of `result` is 0.
- R9: The value on `result` in a cycle where `wr_en` is high is the value the destination holds after that cycle's rising edge. No extra latency is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 2 | Register driven onto bus A |
| b_sel | input | 2 | Register driven onto bus B |
| b_use_const | input | 1 | Put const_in on bus B in place of a register |
| const_in | input | W | External constant |
| alu_op | input | 3 | ALU operation code |
| shift_op | input | 2 | Shifter operation code |
| use_shifter | input | 1 | 1 selects the shifter output, 0 the ALU output |
| dst_sel | input | 2 | Destination register index |
| wr_en | input | 1 | Write enable for the destination |
| bus_a | output | W | Bus A value |
| bus_b | output | W | Bus B value |
| result | output | W | Function unit result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result MSB |
| flag_z | output | 1 | Result is zero |

## Verification
The bench targets several corner cases, each tied to a way a faulty design would go wrong:

- **Read during write.** A design that forwards the write data would show the new value on the bus one cycle early.
- **Carry and overflow edges.** The tests include incrementing 0x7F and 0xFF, and subtracting a larger value from a smaller one. An adder with a misplaced carry-in, or one that takes overflow from the wrong bits, gives the wrong C or V here.
- **Shifts of 0x81.** These show whether the fill bit is really zero and whether the end bit is dropped.
- **Random mixes.** Random operations with random writes and reads show any write that leaks into a neighbouring register, or a constant that appears on bus B while the register path is selected.

// File: rtl/dp_pkg.sv
package dp_pkg;
    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_INC  = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_NOT  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_PASS  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_HOLD  = 2'd3
    } shift_op_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int W = 8,
    parameter int N = 4,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] ra_addr,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);
    logic [N-1:0][W-1:0] regs;
    logic [N-1:0]        load;

    for (genvar i = 0; i < N; i++) begin : g_reg
        assign load[i] = wr_en && (wr_addr == AW'(i));

        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (load[i])
                regs[i] <= wr_data;
        end
    end

    // Reads come straight from the registers, so a same-cycle write is not forwarded.
    assign rd_a = regs[ra_addr];
    assign rd_b = regs[rb_addr];

    // R3: at most one register loads per edge
    a_r3_one_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load));

    // R3: nothing changes without a write
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

    // R1: reset leaves every register at zero
    a_r1_clear: assert property (@(posedge clk)
        rst |=> (regs == '0));
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         c,
    output logic         v
);
    logic [W-1:0] addend;
    logic         cin;
    logic [W:0]   sum;
    logic         arith;

    always_comb begin
        unique case (op)
            OP_INC:  begin addend = '0; cin = 1'b1; end
            OP_ADD:  begin addend = b;  cin = 1'b0; end
            OP_SUB:  begin addend = ~b; cin = 1'b1; end
            default: begin addend = '0; cin = 1'b0; end
        endcase
    end

    assign sum   = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, cin};
    assign arith = (op == OP_INC) || (op == OP_ADD) || (op == OP_SUB);

    always_comb begin
        unique case (op)
            OP_PASS: y = a;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            default: y = sum[W-1:0];
        endcase
    end

    assign c = arith && sum[W];
    assign v = arith && (a[W-1] == addend[W-1]) && (sum[W-1] != a[W-1]);

    // R5: subtraction carry means no borrow
    always_comb begin
        if (op == OP_SUB)
            a_r5_sub_carry: assert (c == (a >= b));
    end
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  shift_op_e    op,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_comb begin
        unique case (op)
            SH_LEFT:  q = {d[W-2:0], 1'b0};
            SH_RIGHT: q = {1'b0, d[W-1:1]};
            default:  q = d;
        endcase
    end

    // R7: the fill bit is zero
    always_comb begin
        if (op == SH_LEFT)
            a_r7_left_fill: assert (q[0] == 1'b0);
        if (op == SH_RIGHT)
            a_r7_right_fill: assert (q[W-1] == 1'b0);
    end
endmodule

// File: rtl/regfile_datapath.sv
module regfile_datapath
    import dp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   a_sel,
    input  logic [1:0]   b_sel,
    input  logic         b_use_const,
    input  logic [W-1:0] const_in,
    input  logic [2:0]   alu_op,
    input  logic [1:0]   shift_op,
    input  logic         use_shifter,
    input  logic [1:0]   dst_sel,
    input  logic         wr_en,
    output logic [W-1:0] bus_a,
    output logic [W-1:0] bus_b,
    output logic [W-1:0] result,
    output logic         flag_v,
    output logic         flag_c,
    output logic         flag_n,
    output logic         flag_z
);
    localparam int NREG = 4;

    logic [W-1:0] reg_b;
    logic [W-1:0] alu_y;
    logic [W-1:0] sh_q;
    logic         alu_c;
    logic         alu_v;

    dp_regfile #(.W(W), .N(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (dst_sel),
        .wr_data (result),
        .ra_addr (a_sel),
        .rb_addr (b_sel),
        .rd_a    (bus_a),
        .rd_b    (reg_b)
    );

    assign bus_b = b_use_const ? const_in : reg_b;

    dp_alu #(.W(W)) u_alu (
        .op (alu_op_e'(alu_op)),
        .a  (bus_a),
        .b  (bus_b),
        .y  (alu_y),
        .c  (alu_c),
        .v  (alu_v)
    );

    dp_shifter #(.W(W)) u_sh (
        .op (shift_op_e'(shift_op)),
        .d  (bus_b),
        .q  (sh_q)
    );

    always_comb begin
        result = use_shifter ? sh_q : alu_y;
        flag_c = !use_shifter && alu_c;
        flag_v = !use_shifter && alu_v;
        flag_n = result[W-1];
        flag_z = (result == '0);
    end

    // R9: a written result is visible on bus A the next cycle
    a_r9_writeback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (a_sel != $past(dst_sel)) || (bus_a == $past(result)));

    // R2: the constant path overrides the register on bus B
    a_r2_const: assert property (@(posedge clk) disable iff (rst)
        b_use_const |-> (bus_b == const_in));
endmodule

// File: tb/sim_regfile_datapath.sv
module sim_regfile_datapath;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   a_sel = '0, b_sel = '0, dst_sel = '0, shift_op = '0;
    logic         b_use_const = 1'b0, use_shifter = 1'b0, wr_en = 1'b0;
    logic [W-1:0] const_in = '0;
    logic [2:0]   alu_op = '0;
    logic [W-1:0] bus_a, bus_b, result;
    logic         flag_v, flag_c, flag_n, flag_z;

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    int model [4];
    int e_a, e_b, e_res, e_c, e_v;

    always #(CLK_PERIOD/2) clk = ~clk;

    regfile_datapath #(.W(W)) u0 (
        .clk(clk), .rst(rst), .a_sel(a_sel), .b_sel(b_sel),
        .b_use_const(b_use_const), .const_in(const_in), .alu_op(alu_op),
        .shift_op(shift_op), .use_shifter(use_shifter), .dst_sel(dst_sel),
        .wr_en(wr_en), .bus_a(bus_a), .bus_b(bus_b), .result(result),
        .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
    );

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    // Behavioural reference for the current cycle
    task automatic model_eval();
        int s;
        int sa, sb, sr;
        e_a = model[a_sel];
        e_b = b_use_const ? int'(const_in) : model[b_sel];
        e_c = 0;
        e_v = 0;
        if (use_shifter) begin
            if (shift_op == 2'd1)      e_res = (e_b * 2) % 256;
            else if (shift_op == 2'd2) e_res = e_b / 2;
            else                       e_res = e_b;
        end else begin
            sa = e_a >= 128 ? e_a - 256 : e_a;
            sb = e_b >= 128 ? e_b - 256 : e_b;
            case (alu_op)
                3'd0: e_res = e_a;
                3'd1: begin s = e_a + 1; e_res = s % 256; e_c = s / 256; sr = sa + 1;
                      e_v = (sr > 127) ? 1 : 0; end
                3'd2: begin s = e_a + e_b; e_res = s % 256; e_c = s / 256; sr = sa + sb;
                      e_v = (sr > 127 || sr < -128) ? 1 : 0; end
                3'd3: begin e_res = (e_a - e_b + 256) % 256; e_c = (e_a >= e_b) ? 1 : 0;
                      sr = sa - sb; e_v = (sr > 127 || sr < -128) ? 1 : 0; end
                3'd4: e_res = e_a & e_b;
                3'd5: e_res = e_a | e_b;
                3'd6: e_res = e_a ^ e_b;
                default: e_res = (~e_a) & 255;
            endcase
        end
    endtask

    task automatic step(int as, int bs, int uc, int k, int op, int sh, int us, int ds, int we);
        @(negedge clk);
        a_sel = 2'(as); b_sel = 2'(bs); b_use_const = uc[0]; const_in = W'(k);
        alu_op = 3'(op); shift_op = 2'(sh); use_shifter = us[0];
        dst_sel = 2'(ds); wr_en = we[0];
        #1;
        model_eval();
        check("R2 bus_a", int'(bus_a), e_a);
        check("R2 bus_b", int'(bus_b), e_b);
        check(us != 0 ? "R7 result" : (op >= 4 ? "R6 result" : "R5 result"), int'(result), e_res);
        check(op >= 4 || us != 0 ? "R6 flag_c" : "R5 flag_c", int'(flag_c), e_c);
        check(op >= 4 || us != 0 ? "R6 flag_v" : "R5 flag_v", int'(flag_v), e_v);
        check("R8 flag_n", int'(flag_n), e_res / 128);
        check("R8 flag_z", int'(flag_z), e_res == 0 ? 1 : 0);
        @(posedge clk);
        if (we != 0) model[ds] = e_res;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: all registers read zero after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a_sel = 2'(i); b_sel = 2'(3 - i); b_use_const = 1'b0; wr_en = 1'b0;
            #1;
            check("R1 bus_a after reset", int'(bus_a), 0);
            check("R1 bus_b after reset", int'(bus_b), 0);
        end
        // R3 / R9: load distinct constants through the shifter pass path
        for (int i = 0; i < 4; i++) step(0, 0, 1, 16 * i + 5, 0, 0, 1, i, 1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            a_sel = 2'(i); wr_en = 1'b0; #1;
            check("R3 register contents", int'(bus_a), 16 * i + 5);
        end
        // R4: read and write r1 in the same cycle
        @(negedge clk);
        a_sel = 2'd1; b_sel = 2'd0; b_use_const = 1'b1; const_in = 8'hAA;
        use_shifter = 1'b1; shift_op = 2'd0; dst_sel = 2'd1; wr_en = 1'b1;
        #1;
        check("R4 old value during write", int'(bus_a), model[1]);
        @(posedge clk);
        model[1] = 8'hAA;
        @(negedge clk);
        wr_en = 1'b0; #1;
        check("R4 new value next cycle", int'(bus_a), 8'hAA);
        // R3: write disabled leaves r2 alone
        step(2, 0, 1, 8'h33, 0, 0, 1, 2, 0);
        step(2, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R3 no write when disabled", int'(bus_a), 16 * 2 + 5);
        // R5 corners
        step(0, 0, 1, 8'h7F, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 1, 0, 0, 3, 0);
        check("R5 inc overflow", int'(flag_v), 1);
        step(0, 0, 1, 8'hFF, 0, 0, 1, 0, 1);
        step(0, 0, 0, 0, 1, 0, 0, 3, 1);
        step(3, 0, 1, 1, 3, 0, 0, 2, 0);
        check("R5 zero minus one borrow", int'(flag_c), 0);
        step(0, 0, 1, 8'h80, 3, 0, 0, 2, 0);
        // R7 corners
        step(0, 0, 1, 8'h81, 0, 1, 1, 2, 0);
        check("R7 left of 81", int'(result), 8'h02);
        step(0, 0, 1, 8'h81, 0, 2, 1, 2, 0);
        check("R7 right of 81", int'(result), 8'h40);
        step(0, 0, 1, 8'h81, 0, 3, 1, 2, 0);
        // R8 zero
        step(1, 1, 0, 0, 6, 0, 0, 0, 0);
        // random mix
        for (int n = 0; n < 400; n++)
            step(int'($urandom % 4), int'($urandom % 4), int'($urandom % 2), int'($urandom % 256),
                 int'($urandom % 8), int'($urandom % 4), int'($urandom % 2),
                 int'($urandom % 4), int'($urandom % 2));
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule